// File: doc/BRIEF.md
# Sequential Line Prefetch Buffers

This block sits next to a data cache and keeps a few small FIFOs. Each FIFO follows one run of consecutive cache lines and fetches them before they are needed. The cache reports each load miss as a line address. The block compares that address with the oldest entry of every FIFO at once. If an oldest entry matches, the block removes it and returns its data as the fill. If nothing matches, the block answers "no hit", so the cache fetches the line itself. The block also starts a new run at the next line, in a FIFO that is free or, when all are busy, in the one used longest ago.

In the background, every FIFO that has a free slot asks the memory port for its next line. A round-robin choice picks among the FIFOs that are asking. Each request carries a buffer number, a slot number and a generation count. Memory returns these with the data, so a reply for a FIFO that has since been reused is recognised and dropped.

Handshake rules. A miss is taken when `miss_valid` and `miss_ready` are both high. Only one miss is in flight at a time, and `miss_ready` stays low until its fill has been taken. `fill_valid` stays high with a steady payload until `fill_ready` is seen. A memory request is sent when `mreq_valid` and `mreq_ready` are both high. While `mreq_ready` is low, `mreq_valid` stays high. Memory replies are always accepted.

Top module: `sbp_stream_prefetch`

## Requirements
- R1: After reset `miss_ready` is 1, and `fill_valid` and `mreq_valid` are 0, because no FIFO is in use.
- R2: Only the oldest entry of a FIFO takes part in the compare. A miss on a line held deeper in a FIFO gets `fill_hit`=0.
- R3: A miss that matches an oldest entry whose data has arrived returns `fill_hit`=1 and that line's data. The entry is removed, so a second miss on the same line does not hit.
- R4: A miss with no match returns `fill_hit`=0 and starts a FIFO whose first memory request is for the miss line plus one.
- R5: When all FIFOs are in use, a miss with no match reuses the FIFO that was least recently used. Lines that FIFO held no longer hit.
- R6: A FIFO in use with fewer than DEPTH entries requests its next line (the previous line plus one). While `mreq_ready` is 0, no request is taken and `mreq_valid` stays 1.
- R7: A miss that matches an oldest entry still waiting for memory waits for that data, then returns it with `fill_hit`=1. No second request is made for that line.
- R8: A memory reply whose generation does not match the FIFO's current generation is dropped. It never becomes fill data.
- R9: When several FIFOs ask at once, the requests are granted in rotating order. The same FIFO is not granted twice in a row while another FIFO is waiting.
- R10: A hit makes the matching FIFO the most recently used.
- R11: `fill_valid` stays high with stable `fill_hit` and `fill_data` until `fill_ready`. Meanwhile `miss_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | Load miss offered |
| miss_ready | output | 1 | Block can take a miss |
| miss_line | input | AW | Line address of the miss |
| fill_valid | output | 1 | Result of the current miss is ready |
| fill_ready | input | 1 | Cache takes the result |
| fill_hit | output | 1 | 1: data came from a FIFO; 0: the cache must fetch the line |
| fill_data | output | DW | Line data when `fill_hit` is 1, else 0 |
| mreq_valid | output | 1 | Prefetch request offered |
| mreq_ready | input | 1 | Memory port is free to take a request |
| mreq_line | output | AW | Line to fetch |
| mreq_buf | output | log2(NBUF) | Number of the requesting FIFO |
| mreq_slot | output | log2(DEPTH) | Slot that will receive the data |
| mreq_gen | output | GEN_W | Generation of the requesting FIFO |
| mrsp_valid | input | 1 | Memory reply present |
| mrsp_buf | input | log2(NBUF) | FIFO number, echoed from the request |
| mrsp_slot | input | log2(DEPTH) | Slot number, echoed from the request |
| mrsp_gen | input | GEN_W | Generation, echoed from the request |
| mrsp_data | input | DW | Line data |

## Verification
A wrong head pointer or entry count shows up on the next miss to that FIFO: it reports a wrong hit or miss, or returns data that belongs to a nearby line. A wrong generation or slot shows up only when a late reply is written into a reused FIFO. The bench therefore holds memory replies back across a reuse, then checks the data of the next hit. Arbiter or age-order faults change the order of lines on the request port, or change which FIFO a later miss still hits. These are visible within a few misses of the fault.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WAIT = 2'd2,
    ST_RESP = 2'd3
  } sbp_state_e;

endpackage

// File: rtl/sbp_rr_arb.sv
module sbp_rr_arb #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  input  logic                 adv,
  output logic [N-1:0]         gnt,
  output logic [$clog2(N)-1:0] gnt_idx,
  output logic                 any
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] last_q;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(last_q) + k) % N;
      if (!any && req[j]) begin
        any     = 1'b1;
        gnt[j]  = 1'b1;
        gnt_idx = IW'(j);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else if (adv && any) last_q <= gnt_idx;
  end

  // R9: after a taken grant, another waiting requester is served next
  p_rr_rotate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && any) |=> (((req & ~$past(gnt)) == '0) || (gnt != $past(gnt))));

endmodule

// File: rtl/sbp_lru.sv
module sbp_lru #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 touch,
  input  logic [$clog2(N)-1:0] touch_idx,
  output logic [$clog2(N)-1:0] victim
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] age_q [N];
  logic [N-1:0]  oldest;

  always_comb begin
    victim = '0;
    for (int i = 0; i < N; i++) begin
      oldest[i] = (age_q[i] == IW'(N - 1));
      if (oldest[i]) victim = IW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  // R5: exactly one buffer is the oldest at any time
  p_single_oldest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest) == 1);

  // R10: a touched buffer becomes the youngest
  p_touch_mru_r10: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> age_q[$past(touch_idx)] == '0);

endmodule

// File: rtl/sbp_buffer.sv
module sbp_buffer #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 2,
  parameter int GEN_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc,
  input  logic [AW-1:0]            alloc_line,
  input  logic                     grant,
  input  logic                     pop,
  input  logic                     rsp_valid,
  input  logic [$clog2(DEPTH)-1:0] rsp_slot,
  input  logic [GEN_W-1:0]         rsp_gen,
  input  logic [DW-1:0]            rsp_data,
  output logic                     in_use,
  output logic                     want,
  output logic [AW-1:0]            req_line,
  output logic [$clog2(DEPTH)-1:0] req_slot,
  output logic [GEN_W-1:0]         gen,
  output logic                     has_head,
  output logic [AW-1:0]            head_line,
  output logic                     head_full,
  output logic [DW-1:0]            head_data
);
  localparam int SW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    next_q;
  logic [SW-1:0]    head_q;
  logic [CW-1:0]    cnt_q;
  logic [AW-1:0]    line_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] pend_q;
  logic [DEPTH-1:0] full_q;
  logic [SW-1:0]    tail;
  logic             rsp_take;

  assign tail      = head_q + SW'(cnt_q);
  assign want      = in_use && (cnt_q < CW'(DEPTH));
  assign req_line  = next_q;
  assign req_slot  = tail;
  assign has_head  = (cnt_q != '0);
  assign head_line = line_q[head_q];
  assign head_full = full_q[head_q];
  assign head_data = data_q[head_q];
  assign rsp_take  = rsp_valid && (rsp_gen == gen) && pend_q[rsp_slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_use <= 1'b0;
      gen    <= '0;
      next_q <= '0;
      head_q <= '0;
      cnt_q  <= '0;
      pend_q <= '0;
      full_q <= '0;
      for (int s = 0; s < DEPTH; s++) begin
        line_q[s] <= '0;
        data_q[s] <= '0;
      end
    end else if (alloc) begin
      in_use <= 1'b1;
      gen    <= gen + 1'b1;
      next_q <= alloc_line + 1'b1;
      head_q <= '0;
      cnt_q  <= '0;
      pend_q <= '0;
      full_q <= '0;
    end else begin
      if (rsp_take) begin
        pend_q[rsp_slot] <= 1'b0;
        full_q[rsp_slot] <= 1'b1;
        data_q[rsp_slot] <= rsp_data;
      end
      if (grant) begin
        line_q[tail] <= next_q;
        pend_q[tail] <= 1'b1;
        full_q[tail] <= 1'b0;
        next_q       <= next_q + 1'b1;
      end
      if (pop) begin
        full_q[head_q] <= 1'b0;
        head_q         <= head_q + 1'b1;
      end
      cnt_q <= cnt_q + CW'(grant) - CW'(pop);
    end
  end

  // R3: an entry is removed only when it holds returned data
  p_pop_filled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (has_head && head_full));

  // R6: no request is granted into a full FIFO
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (cnt_q < CW'(DEPTH)));

  // R6: a granted request moves the stream on by exactly one line
  p_stream_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !alloc) |=> next_q == $past(next_q) + 1'b1);

endmodule

// File: rtl/sbp_stream_prefetch.sv
module sbp_stream_prefetch
  import sbp_pkg::*;
#(
  parameter int NBUF  = 4,
  parameter int DEPTH = 2,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int GEN_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     miss_valid,
  output logic                     miss_ready,
  input  logic [AW-1:0]            miss_line,
  output logic                     fill_valid,
  input  logic                     fill_ready,
  output logic                     fill_hit,
  output logic [DW-1:0]            fill_data,
  output logic                     mreq_valid,
  input  logic                     mreq_ready,
  output logic [AW-1:0]            mreq_line,
  output logic [$clog2(NBUF)-1:0]  mreq_buf,
  output logic [$clog2(DEPTH)-1:0] mreq_slot,
  output logic [GEN_W-1:0]         mreq_gen,
  input  logic                     mrsp_valid,
  input  logic [$clog2(NBUF)-1:0]  mrsp_buf,
  input  logic [$clog2(DEPTH)-1:0] mrsp_slot,
  input  logic [GEN_W-1:0]         mrsp_gen,
  input  logic [DW-1:0]            mrsp_data
);
  localparam int IW = $clog2(NBUF);
  localparam int SW = $clog2(DEPTH);

  sbp_state_e    state_q, state_d;
  logic [AW-1:0] miss_q;
  logic [IW-1:0] sel_q, sel_d;
  logic          hit_q;
  logic [DW-1:0] data_q;

  logic [NBUF-1:0] b_in_use, b_want, b_has_head, b_head_full;
  logic [NBUF-1:0] pop_v, alloc_v, gnt_v;
  logic [AW-1:0]   b_req_line  [NBUF];
  logic [AW-1:0]   b_head_line [NBUF];
  logic [SW-1:0]   b_req_slot  [NBUF];
  logic [GEN_W-1:0] b_gen      [NBUF];
  logic [DW-1:0]   b_head_data [NBUF];

  logic          hit_any, free_any, arb_any, touch, ld, ld_hit, mreq_fire;
  logic [IW-1:0] hit_idx, free_idx, lru_victim, victim, touch_idx, gnt_idx;
  logic [DW-1:0] ld_data;

  // Round-robin choice among FIFOs asking for their next line
  sbp_rr_arb #(.N(NBUF)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(b_want), .adv(mreq_fire),
    .gnt(gnt_v), .gnt_idx(gnt_idx), .any(arb_any)
  );

  sbp_lru #(.N(NBUF)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch(touch), .touch_idx(touch_idx),
    .victim(lru_victim)
  );

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    sbp_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .GEN_W(GEN_W)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .alloc(alloc_v[g]), .alloc_line(miss_q),
      .grant(gnt_v[g] && mreq_ready), .pop(pop_v[g]),
      .rsp_valid(mrsp_valid && (mrsp_buf == IW'(g))),
      .rsp_slot(mrsp_slot), .rsp_gen(mrsp_gen), .rsp_data(mrsp_data),
      .in_use(b_in_use[g]), .want(b_want[g]),
      .req_line(b_req_line[g]), .req_slot(b_req_slot[g]), .gen(b_gen[g]),
      .has_head(b_has_head[g]), .head_line(b_head_line[g]),
      .head_full(b_head_full[g]), .head_data(b_head_data[g])
    );
  end

  // Request port: payload of the granted FIFO
  assign mreq_valid = arb_any;
  assign mreq_fire  = mreq_valid && mreq_ready;
  assign mreq_line  = b_req_line[gnt_idx];
  assign mreq_slot  = b_req_slot[gnt_idx];
  assign mreq_gen   = b_gen[gnt_idx];
  assign mreq_buf   = gnt_idx;

  // Parallel head compare, lowest index wins
  always_comb begin
    hit_any  = 1'b0;
    hit_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (!hit_any && b_in_use[i] && b_has_head[i] && (b_head_line[i] == miss_q)) begin
        hit_any = 1'b1;
        hit_idx = IW'(i);
      end
      if (!free_any && !b_in_use[i]) begin
        free_any = 1'b1;
        free_idx = IW'(i);
      end
    end
    victim = free_any ? free_idx : lru_victim;
  end

  always_comb begin
    state_d   = state_q;
    sel_d     = sel_q;
    pop_v     = '0;
    alloc_v   = '0;
    touch     = 1'b0;
    touch_idx = hit_idx;
    ld        = 1'b0;
    ld_hit    = 1'b0;
    ld_data   = '0;
    unique case (state_q)
      ST_IDLE: if (miss_valid) state_d = ST_LOOK;
      ST_LOOK: begin
        touch = 1'b1;
        if (hit_any) begin
          sel_d = hit_idx;
          if (b_head_full[hit_idx]) begin
            pop_v[hit_idx] = 1'b1;
            ld      = 1'b1;
            ld_hit  = 1'b1;
            ld_data = b_head_data[hit_idx];
            state_d = ST_RESP;
          end else begin
            state_d = ST_WAIT;
          end
        end else begin
          touch_idx       = victim;
          alloc_v[victim] = 1'b1;
          ld      = 1'b1;
          state_d = ST_RESP;
        end
      end
      ST_WAIT: if (b_head_full[sel_q]) begin
        pop_v[sel_q] = 1'b1;
        ld      = 1'b1;
        ld_hit  = 1'b1;
        ld_data = b_head_data[sel_q];
        state_d = ST_RESP;
      end
      ST_RESP: if (fill_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      miss_q  <= '0;
      sel_q   <= '0;
      hit_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      if (miss_valid && miss_ready) miss_q <= miss_line;
      if (ld) begin
        hit_q  <= ld_hit;
        data_q <= ld_data;
      end
    end
  end

  assign miss_ready = (state_q == ST_IDLE);
  assign fill_valid = (state_q == ST_RESP);
  assign fill_hit   = hit_q;
  assign fill_data  = data_q;

  // R11: result holds until taken
  p_fill_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_ready) |=> (fill_valid && $stable(fill_hit) && $stable(fill_data)));

  // R11: one miss in flight
  p_one_miss_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !miss_ready);

  // R6: a refused request stays offered
  p_req_persist_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> mreq_valid);

  // R7: while waiting, the chosen FIFO still heads the missed line
  p_wait_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (b_in_use[sel_q] && b_has_head[sel_q] && (b_head_line[sel_q] == miss_q)));

endmodule

// File: tb/tb_sbp_stream_prefetch.sv
`timescale 1ns/1ps
module tb_sbp_stream_prefetch;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [15:0] miss_line = '0;
  logic        fill_valid, fill_ready = 1'b1, fill_hit;
  logic [31:0] fill_data;
  logic        mreq_valid, mreq_ready = 1'b1;
  logic [15:0] mreq_line;
  logic [1:0]  mreq_buf;
  logic [0:0]  mreq_slot;
  logic [1:0]  mreq_gen;
  logic        mrsp_valid = 1'b0;
  logic [1:0]  mrsp_buf = '0;
  logic [0:0]  mrsp_slot = '0;
  logic [1:0]  mrsp_gen = '0;
  logic [31:0] mrsp_data = '0;

  int n_cmp = 0, n_bad = 0, cyc = 0, wr = 0, rd = 0;
  bit hold = 1'b0;
  logic [15:0] q_line [256];
  logic [1:0]  q_buf  [256];
  logic [0:0]  q_slot [256];
  logic [1:0]  q_gen  [256];
  int          q_due  [256];

  always #2.5 clk = ~clk;

  sbp_stream_prefetch dut (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_line(miss_line),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_hit(fill_hit), .fill_data(fill_data),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_line(mreq_line),
    .mreq_buf(mreq_buf), .mreq_slot(mreq_slot), .mreq_gen(mreq_gen),
    .mrsp_valid(mrsp_valid), .mrsp_buf(mrsp_buf), .mrsp_slot(mrsp_slot),
    .mrsp_gen(mrsp_gen), .mrsp_data(mrsp_data)
  );

  function automatic logic [31:0] memf(input logic [15:0] l);
    return {l, ~l};
  endfunction

  // Memory model: log taken requests, answer in order after LAT cycles
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && mreq_valid && mreq_ready) begin
      q_line[wr] <= mreq_line;
      q_buf[wr]  <= mreq_buf;
      q_slot[wr] <= mreq_slot;
      q_gen[wr]  <= mreq_gen;
      q_due[wr]  <= cyc + LAT;
      wr <= wr + 1;
    end
  end

  always @(negedge clk) begin
    if (!hold && rd < wr && q_due[rd] <= cyc) begin
      mrsp_valid = 1'b1;
      mrsp_buf   = q_buf[rd];
      mrsp_slot  = q_slot[rd];
      mrsp_gen   = q_gen[rd];
      mrsp_data  = memf(q_line[rd]);
      rd = rd + 1;
    end else begin
      mrsp_valid = 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic do_reset();
    while (rd != wr) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_miss(input logic [15:0] l, output logic h, output logic [31:0] d);
    @(negedge clk);
    while (!miss_ready) @(negedge clk);
    miss_valid = 1'b1;
    miss_line  = l;
    @(negedge clk);
    miss_valid = 1'b0;
    while (!fill_valid) @(negedge clk);
    h = fill_hit;
    d = fill_data;
  endtask

  task automatic expect_miss(input logic [15:0] l, input logic eh, input string tag);
    logic h;
    logic [31:0] d;
    do_miss(l, h, d);
    check(h == eh, tag, 32'(h), 32'(eh));
    if (eh) check(d == memf(l), tag, d, memf(l));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int base;
    logic h;
    logic [31:0] d;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(miss_ready == 1'b1, "R1 miss_ready", 32'(miss_ready), 1);
    check(fill_valid == 1'b0, "R1 fill_valid", 32'(fill_valid), 0);
    check(mreq_valid == 1'b0, "R1 mreq_valid", 32'(mreq_valid), 0);

    // R4 / R6: cold miss starts a stream at line+1 and stops when full
    base = wr;
    expect_miss(16'h0100, 1'b0, "R4 cold miss");
    repeat (20) @(negedge clk);
    check(wr - base == 2, "R6 fills to depth", 32'(wr - base), 2);
    check(q_line[base] == 16'h0101, "R4 first request", 32'(q_line[base]), 32'h0101);
    check(q_line[base+1] == 16'h0102, "R6 next line", 32'(q_line[base+1]), 32'h0102);

    // R3 / R7: sequential sweep of head hits, ready or pending
    for (int k = 1; k <= 24; k++) expect_miss(16'h0100 + 16'(k), 1'b1, "R3 sweep hit");
    repeat (10) @(negedge clk);
    check(wr - base == 26, "R7 no duplicate request", 32'(wr - base), 26);
    ok = 1'b1;
    for (int i = 0; i < 26; i++) if (q_line[base+i] != 16'h0101 + 16'(i)) ok = 1'b0;
    check(ok, "R7 request order", 32'(ok), 1);
    // R3: popped line no longer hits
    expect_miss(16'h0118, 1'b0, "R3 popped line");

    // R2: a non-head entry does not hit, head stays intact
    do_reset();
    expect_miss(16'h0200, 1'b0, "R2 alloc");
    repeat (15) @(negedge clk);
    expect_miss(16'h0202, 1'b0, "R2 non-head");
    expect_miss(16'h0201, 1'b1, "R2 head kept");

    // R5 / R10: least recently used reuse
    do_reset();
    expect_miss(16'h1000, 1'b0, "R4 alloc b0");
    expect_miss(16'h2000, 1'b0, "R4 alloc b1");
    expect_miss(16'h3000, 1'b0, "R4 alloc b2");
    expect_miss(16'h4000, 1'b0, "R4 alloc b3");
    repeat (20) @(negedge clk);
    expect_miss(16'h1001, 1'b1, "R10 touch");
    expect_miss(16'h5000, 1'b0, "R5 recycle");
    repeat (20) @(negedge clk);
    expect_miss(16'h5001, 1'b1, "R5 new stream");
    expect_miss(16'h1002, 1'b1, "R10 kept mru");
    expect_miss(16'h3001, 1'b1, "R5 kept");
    expect_miss(16'h4001, 1'b1, "R5 kept");
    expect_miss(16'h2001, 1'b0, "R5 victim gone");

    // R8: late replies for a reused FIFO are dropped
    do_reset();
    hold = 1'b1;
    expect_miss(16'h1000, 1'b0, "R8 setup");
    expect_miss(16'h2000, 1'b0, "R8 setup");
    expect_miss(16'h3000, 1'b0, "R8 setup");
    expect_miss(16'h4000, 1'b0, "R8 setup");
    repeat (10) @(negedge clk);
    expect_miss(16'h5000, 1'b0, "R8 reuse");
    repeat (10) @(negedge clk);
    hold = 1'b0;
    repeat (40) @(negedge clk);
    expect_miss(16'h5001, 1'b1, "R8 fresh data");
    expect_miss(16'h5002, 1'b1, "R8 fresh data");
    expect_miss(16'h1001, 1'b0, "R5 reused lines gone");

    // R6 / R9: back-pressure then rotating grants
    do_reset();
    mreq_ready = 1'b0;
    base = wr;
    expect_miss(16'h1000, 1'b0, "R9 setup");
    expect_miss(16'h2000, 1'b0, "R9 setup");
    expect_miss(16'h3000, 1'b0, "R9 setup");
    repeat (5) @(negedge clk);
    check(mreq_valid == 1'b1, "R6 held valid", 32'(mreq_valid), 1);
    check(wr == base, "R6 nothing taken", 32'(wr - base), 0);
    mreq_ready = 1'b1;
    repeat (20) @(negedge clk);
    check(wr - base == 6, "R9 total", 32'(wr - base), 6);
    for (int i = 0; i < 5; i++)
      check(q_buf[base+i] != q_buf[base+i+1], "R9 rotate", 32'(q_buf[base+i+1]), 32'(q_buf[base+i]));
    for (int i = 0; i < 3; i++) begin
      check(q_buf[base+i+3] == q_buf[base+i], "R9 period", 32'(q_buf[base+i+3]), 32'(q_buf[base+i]));
      check(q_line[base+i+3] == q_line[base+i] + 16'd1, "R6 sequence",
            32'(q_line[base+i+3]), 32'(q_line[base+i] + 16'd1));
    end

    // R11: fill back-pressure
    fill_ready = 1'b0;
    do_miss(16'h7000, h, d);
    ok = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!fill_valid || fill_hit != h || fill_data != d || miss_ready) ok = 1'b0;
    end
    check(ok, "R11 hold", 32'(ok), 1);
    fill_ready = 1'b1;
    @(negedge clk);
    check(fill_valid == 1'b0, "R11 taken", 32'(fill_valid), 0);
    check(miss_ready == 1'b1, "R11 ready again", 32'(miss_ready), 1);

    summary();
    $finish;
  end

endmodule